// File: doc/BRIEF.md
# Clock Divider Best-Match Search

This block picks the best source clock for a requested frequency. It keeps a table of up to `LEVELS` source frequencies, which are loaded one entry at a time through a simple write port in ascending order. On a start pulse it walks the table from entry 0 upward. For each entry it works out the smallest integer divider that keeps the divided clock at or below the request. It then measures how far that divided clock falls short of the request. The entry with the smallest shortfall wins.

The search uses one shared multi-cycle restoring divider, which runs twice per table entry: once for the ceiling divider and once for the divided frequency. The walk stops early as soon as an entry divides down to exactly the requested rate. A per-request exact flag decides what happens when no entry is exact: with the flag set, the result is a failure; with it clear, the closest entry is returned. The result gives the winning entry index, its frequency and its divider, and ends with a one-cycle done pulse. An error flag rides on that pulse.

Top module: `freq_match_search`

## Requirements
- R1: A cycle with `tbl_wr_en` high stores `tbl_wr_data` at entry `tbl_wr_addr` on that clock edge. A search considers at most `LEVELS` entries, so a full table with no terminator is searched in its entirety.
- R2: The valid part of the table ends at the first entry that is zero, or at the first entry equal to the entry before it. Entries from that point onward never influence the result.
- R3: For an entry F and a request Q, the reported divider is ceil(F/Q). The shortfall of that entry is Q − floor(F/divider).
- R4: A later entry replaces the current best only when its shortfall is strictly smaller. When two entries tie, the lower index is kept.
- R5: An entry with zero shortfall ends the search at once, so the later entries are not processed and the result arrives sooner than a full walk of the table.
- R6: With `exact_mode` high, `err` is raised with `done` when the best shortfall is not zero.
- R7: With `exact_mode` low, a non-empty table always yields `err` low. The result is the entry with the smallest shortfall.
- R8: A table whose entry 0 is zero reports `err` with `done`.
- R9: A request of zero is rejected with `err`, and `done` follows two clock edges after the start edge without any table walk.
- R10: `busy` rises on the edge after a start is accepted. It stays high until the edge that raises `done`, where it falls. `done` is a one-cycle pulse, and `err` is only ever high together with `done`.
- R11: After reset, `busy`, `done` and `err` are low and the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_addr | input | IDXW | Entry index to write |
| tbl_wr_data | input | FW | Source frequency for that entry |
| start | input | 1 | Begin a search (taken only while idle) |
| req_freq | input | FW | Requested frequency |
| exact_mode | input | 1 | Demand a zero shortfall |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| best_idx | output | IDXW | Winning entry index |
| best_freq | output | FW | Winning entry frequency |
| best_div | output | FW | Divider for the winning entry |

## Verification
The assertions assume that the table is not rewritten during a search, and that `start` is pulsed only while `busy` is low. The divider is also assumed never to be handed a zero divisor. The stimulus loads each table completely before starting any search. It issues one search at a time and waits for `done` before the next one. The zero-request case goes through the rejection path, so the divider only ever sees the request itself or a computed ceiling, and both of those are at least one. Expected results come from an arithmetic model in the bench, swept over every request in a range against several small tables.

// File: rtl/freq_match_pkg.sv
package freq_match_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_DIV1  = 3'd2,
      ST_DIV2  = 3'd3,
      ST_DONE  = 3'd4
   } fm_state_e;

endpackage

// File: rtl/freq_match_table.sv
module freq_match_table #(
   parameter int FW     = 32,
   parameter int LEVELS = 32,
   localparam int IDXW  = $clog2(LEVELS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_addr,
   input  logic [FW-1:0]   wr_data,
   input  logic [IDXW-1:0] rd_addr,
   output logic [FW-1:0]   rd_data
);

   logic [FW-1:0] entry_q [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entry_q[g] <= '0;
         end else if (wr_en && (wr_addr == IDXW'(g))) begin
            entry_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (rd_addr == IDXW'(i)) rd_data = entry_q[i];
      end
   end

endmodule

// File: rtl/freq_match_divider.sv
module freq_match_divider #(
   parameter int W     = 32,
   localparam int CW   = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   logic [W-1:0]  part_q, quo_q, den_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;
   logic [W:0]    trial;
   logic          take;
   logic [W-1:0]  part_n;

   always_comb begin
      trial  = {part_q, quo_q[W-1]};
      take   = (trial >= {1'b0, den_q});
      part_n = take ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i) begin
            part_q <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(W);
            run_q  <= 1'b1;
         end else if (run_q) begin
            part_q <= part_n;
            quo_q  <= {quo_q[W-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = quo_q;
   assign rem_o  = part_q;

   // R3: a finished division leaves a remainder below its divisor
   a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rem_o < den_q));

   // R3: a new division is never launched over a running one
   a_r3_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !run_q);

   // R3: the divisor handed in is never zero
   a_r3_nonzero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (den_i != '0));

endmodule

// File: rtl/freq_match_ctrl.sv
module freq_match_ctrl
   import freq_match_pkg::*;
#(
   parameter int FW         = 32,
   parameter int LEVELS     = 32,
   parameter int FAST_EXACT = 1,
   localparam int IDXW      = $clog2(LEVELS),
   localparam int CNTW      = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [FW-1:0]   req_i,
   input  logic            exact_i,
   output logic [IDXW-1:0] ent_addr_o,
   input  logic [FW-1:0]   ent_data_i,
   output logic            dv_go_o,
   output logic [FW-1:0]   dv_num_o,
   output logic [FW-1:0]   dv_den_o,
   input  logic            dv_done_i,
   input  logic [FW-1:0]   dv_quo_i,
   input  logic [FW-1:0]   dv_rem_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o,
   output logic [IDXW-1:0] idx_o,
   output logic [FW-1:0]   freq_o,
   output logic [FW-1:0]   div_o
);

   fm_state_e       state_q;
   logic [CNTW-1:0] idx_q;
   logic [FW-1:0]   req_q, cur_q, prev_q, div_q;
   logic [FW-1:0]   best_err_q, best_freq_q, best_div_q;
   logic [IDXW-1:0] best_idx_q;
   logic            exact_q, found_q, dv_go_q, done_q, err_q;

   logic            fast_hit, table_end, eval_now;
   logic [FW-1:0]   ceil_div, cand_err, cand_div;

   // Variant choice: skip the second division when the first is exact
   if (FAST_EXACT != 0) begin : g_fast
      assign fast_hit = (dv_rem_i == '0);
   end else begin : g_full
      assign fast_hit = 1'b0;
   end

   assign ent_addr_o = idx_q[IDXW-1:0];
   assign table_end  = (idx_q == CNTW'(LEVELS)) || (ent_data_i == '0) ||
                       ((idx_q != '0) && (ent_data_i == prev_q));
   assign ceil_div   = dv_quo_i + FW'(dv_rem_i != '0);

   assign dv_go_o  = dv_go_q;
   assign dv_num_o = cur_q;
   assign dv_den_o = (state_q == ST_DIV2) ? div_q : req_q;

   always_comb begin
      eval_now = 1'b0;
      cand_err = '0;
      cand_div = div_q;
      if ((state_q == ST_DIV1) && dv_done_i && fast_hit) begin
         eval_now = 1'b1;
         cand_err = '0;
         cand_div = dv_quo_i;
      end else if ((state_q == ST_DIV2) && dv_done_i) begin
         eval_now = 1'b1;
         cand_err = req_q - dv_quo_i;
         cand_div = div_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         idx_q       <= '0;
         req_q       <= '0;
         cur_q       <= '0;
         prev_q      <= '0;
         div_q       <= '0;
         best_err_q  <= '1;
         best_freq_q <= '0;
         best_div_q  <= '0;
         best_idx_q  <= '0;
         exact_q     <= 1'b0;
         found_q     <= 1'b0;
         dv_go_q     <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         dv_go_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  req_q       <= req_i;
                  exact_q     <= exact_i;
                  idx_q       <= '0;
                  prev_q      <= '0;
                  best_err_q  <= '1;
                  best_freq_q <= '0;
                  best_div_q  <= '0;
                  best_idx_q  <= '0;
                  found_q     <= 1'b0;
                  state_q     <= (req_i == '0) ? ST_DONE : ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (table_end) begin
                  state_q <= ST_DONE;
               end else begin
                  cur_q   <= ent_data_i;
                  dv_go_q <= 1'b1;
                  state_q <= ST_DIV1;
               end
            end
            ST_DIV1: begin
               if (dv_done_i) begin
                  div_q <= ceil_div;
                  if (!fast_hit) begin
                     dv_go_q <= 1'b1;
                     state_q <= ST_DIV2;
                  end
               end
            end
            ST_DIV2: begin
               state_q <= ST_DIV2;
            end
            ST_DONE: begin
               done_q  <= 1'b1;
               err_q   <= !found_q || (exact_q && (best_err_q != '0));
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase

         if (eval_now) begin
            if (cand_err < best_err_q) begin
               best_err_q  <= cand_err;
               best_freq_q <= cur_q;
               best_div_q  <= cand_div;
               best_idx_q  <= idx_q[IDXW-1:0];
               found_q     <= 1'b1;
            end
            if (cand_err == '0) begin
               state_q <= ST_DONE;
            end else begin
               idx_q   <= idx_q + 1'b1;
               prev_q  <= cur_q;
               state_q <= ST_FETCH;
            end
         end
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;
   assign idx_o  = best_idx_q;
   assign freq_o = best_freq_q;
   assign div_o  = best_div_q;

   // R10: completion is reported only once the engine has gone idle
   a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R10: done lasts exactly one cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: the failure flag never appears without done
   a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R4: within one search the best shortfall never grows
   a_r4_best_never_worse: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (best_err_q <= $past(best_err_q)));

   // R1: the walk never goes past the table depth
   a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (idx_q <= CNTW'(LEVELS)));

   // R3: a successful result always carries a nonzero divider
   a_r3_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (div_o != '0));

   // R9: a zero request never launches the divider
   a_r9_zero_req_no_div: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (req_q == '0)) |-> !dv_go_o);

endmodule

// File: rtl/freq_match_search.sv
module freq_match_search #(
   parameter int FW         = 32,
   parameter int LEVELS     = 32,
   parameter int FAST_EXACT = 1,
   localparam int IDXW      = $clog2(LEVELS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tbl_wr_en,
   input  logic [IDXW-1:0] tbl_wr_addr,
   input  logic [FW-1:0]   tbl_wr_data,
   input  logic            start,
   input  logic [FW-1:0]   req_freq,
   input  logic            exact_mode,
   output logic            busy,
   output logic            done,
   output logic            err,
   output logic [IDXW-1:0] best_idx,
   output logic [FW-1:0]   best_freq,
   output logic [FW-1:0]   best_div
);

   if (FW < 2) begin : g_bad_fw
      $error("freq_match_search: FW must be at least 2");
   end
   if (LEVELS < 2) begin : g_bad_levels
      $error("freq_match_search: LEVELS must be at least 2");
   end
   if ((FAST_EXACT != 0) && (FAST_EXACT != 1)) begin : g_bad_fast
      $error("freq_match_search: FAST_EXACT must be 0 or 1");
   end

   logic [IDXW-1:0] ent_addr;
   logic [FW-1:0]   ent_data;
   logic            dv_go, dv_done;
   logic [FW-1:0]   dv_num, dv_den, dv_quo, dv_rem;

   freq_match_table #(.FW(FW), .LEVELS(LEVELS)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_addr (tbl_wr_addr),
      .wr_data (tbl_wr_data),
      .rd_addr (ent_addr),
      .rd_data (ent_data)
   );

   freq_match_divider #(.W(FW)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (dv_go),
      .num_i  (dv_num),
      .den_i  (dv_den),
      .done_o (dv_done),
      .quo_o  (dv_quo),
      .rem_o  (dv_rem)
   );

   freq_match_ctrl #(.FW(FW), .LEVELS(LEVELS), .FAST_EXACT(FAST_EXACT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .req_i      (req_freq),
      .exact_i    (exact_mode),
      .ent_addr_o (ent_addr),
      .ent_data_i (ent_data),
      .dv_go_o    (dv_go),
      .dv_num_o   (dv_num),
      .dv_den_o   (dv_den),
      .dv_done_i  (dv_done),
      .dv_quo_i   (dv_quo),
      .dv_rem_i   (dv_rem),
      .busy_o     (busy),
      .done_o     (done),
      .err_o      (err),
      .idx_o      (best_idx),
      .freq_o     (best_freq),
      .div_o      (best_div)
   );

endmodule

// File: tb/freq_match_search_tb_top.sv
module freq_match_search_tb_top;

   localparam int FW   = 12;
   localparam int LV   = 8;
   localparam int IDXW = $clog2(LV);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tbl_wr_en = 1'b0;
   logic [IDXW-1:0] tbl_wr_addr = '0;
   logic [FW-1:0]   tbl_wr_data = '0;
   logic            start = 1'b0;
   logic [FW-1:0]   req_freq = '0;
   logic            exact_mode = 1'b0;
   logic            busy, done, err;
   logic [IDXW-1:0] best_idx;
   logic [FW-1:0]   best_freq, best_div;

   int n_tests = 0;
   int n_fail  = 0;
   int tbm [LV];

   always #10 clk = ~clk;

   freq_match_search #(.FW(FW), .LEVELS(LV), .FAST_EXACT(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
      .start(start), .req_freq(req_freq), .exact_mode(exact_mode),
      .busy(busy), .done(done), .err(err),
      .best_idx(best_idx), .best_freq(best_freq), .best_div(best_div)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      tbl_wr_en   = 1'b1;
      tbl_wr_addr = IDXW'(addr);
      tbl_wr_data = FW'(data);
      tbm[addr]   = data;
      @(negedge clk);
      tbl_wr_en   = 1'b0;
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < LV; i++) wr(i, 0);
   endtask

   function automatic void model(input int req, input bit ex, output bit e,
                                 output bit fnd, output int idx, output int fr,
                                 output int dv);
      int best;
      best = (1 << FW) - 1;
      e = 1'b0; fnd = 1'b0; idx = 0; fr = 0; dv = 0;
      if (req == 0) begin
         e = 1'b1;
         return;
      end
      for (int i = 0; i < LV; i++) begin
         int en, d, er;
         en = tbm[i];
         if (en == 0) break;
         if ((i > 0) && (en == tbm[i-1])) break;
         d  = (en + req - 1) / req;
         er = req - en / d;
         if (er < best) begin
            best = er; fnd = 1'b1; idx = i; fr = en; dv = d;
         end
         if (er == 0) break;
      end
      e = !fnd || (ex && (best != 0));
   endfunction

   task automatic run(input int req, input bit ex, input string tag, output int lat);
      bit e, fnd;
      int idx, fr, dv;
      model(req, ex, e, fnd, idx, fr, dv);
      @(negedge clk);
      start = 1'b1; req_freq = FW'(req); exact_mode = ex;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      while (!done) begin
         @(negedge clk);
         lat++;
         if (lat > 5000) begin
            chk(1'b0, "watchdog search hung", lat, 0);
            finish_run();
         end
      end
      chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
      chk(err == e, {tag, " err"}, int'(err), int'(e));
      if (fnd) begin
         chk(int'(best_idx) == idx, {tag, " idx"}, int'(best_idx), idx);
         chk(int'(best_freq) == fr, {tag, " freq"}, int'(best_freq), fr);
         chk(int'(best_div) == dv, {tag, " div (R3)"}, int'(best_div), dv);
      end
      @(negedge clk);
      chk(done == 1'b0 && err == 1'b0, "R10 done one-cycle pulse", int'(done), 0);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog global timeout", 0, 1);
      finish_run();
   end

   initial begin
      int lat, lat_hit, lat_full;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy == 0, "R11 busy at reset", int'(busy), 0);
      chk(done == 0, "R11 done at reset", int'(done), 0);
      chk(err == 0, "R11 err at reset", int'(err), 0);
      chk(best_idx == 0 && best_freq == 0 && best_div == 0,
          "R11 results at reset", int'(best_freq), 0);
      rst_n = 1'b1;
      for (int i = 0; i < LV; i++) tbm[i] = 0;

      // R8 empty table
      run(25, 1'b0, "R8 empty table", lat);
      chk(err == 0, "R8 err cleared after pulse", int'(err), 0);

      // R9 zero request rejected in two edges
      wr(0, 40);
      run(0, 1'b0, "R9 zero request", lat);
      chk(lat == 2, "R9 zero request latency", lat, 2);

      // Sweep a short table, both modes (R3 R6 R7)
      clear_tbl();
      wr(0, 10); wr(1, 20); wr(2, 30); wr(3, 45); wr(4, 60);
      for (int q = 1; q <= 70; q++) begin
         run(q, 1'b0, "R7 sweep non-exact", lat);
         run(q, 1'b1, "R6 sweep exact", lat);
      end

      // R6 explicit: no exact entry for 11
      run(11, 1'b1, "R6 exact miss", lat);
      chk(err == 0, "R6 err held only with done", int'(err), 0);

      // R5 early exit: exact hit at entry 0 versus full walk
      run(10, 1'b0, "R5 exact hit", lat_hit);
      run(11, 1'b0, "R5 full walk", lat_full);
      chk(lat_hit < lat_full, "R5 early exit shorter", lat_hit, lat_full);

      // R1 full table, no terminator
      wr(0, 100); wr(1, 150); wr(2, 200); wr(3, 300);
      wr(4, 400); wr(5, 500); wr(6, 700); wr(7, 900);
      for (int q = 1; q <= 950; q += 9) begin
         run(q, 1'b0, "R1 full table non-exact", lat);
         run(q, 1'b1, "R1 full table exact", lat);
      end
      run(900, 1'b1, "R1 last entry reachable", lat);
      chk(int'(best_idx) == 7, "R1 last entry index", int'(best_idx), 7);

      // R2 duplicate entry ends the table; 90 would be exact for 45
      clear_tbl();
      wr(0, 40); wr(1, 50); wr(2, 50); wr(3, 90);
      run(45, 1'b1, "R2 duplicate terminator", lat);
      chk(err == 0 && best_idx == 0, "R2 entry beyond duplicate unused",
          int'(best_idx), 0);

      // R4 tie: 13/2 and 20/3 both give 6 for request 7
      clear_tbl();
      wr(0, 13); wr(1, 20);
      run(7, 1'b0, "R4 tie keeps lower index", lat);
      chk(best_idx == 0 && best_div == 2, "R4 tie index", int'(best_idx), 0);

      finish_run();
   end

endmodule